// File: doc/BRIEF.md
# Dual-Modulus Prescaler with Ratio Select

This block divides one fast input clock by one of four moduli. A ratio-select input picks the short pair (16 or 17) or the long pair (32 or 33). Within that pair, a modulus-control input picks the lower modulus when it is high and the higher modulus when it is low. A frequency synthesiser loop uses the block as its front-end prescaler. A swallow counter drives the modulus control and sees each rising edge of the divided output.

Both mode inputs are captured together, once per output period. The capture happens on the clock edge where the divided output goes high. The captured mode then sets the high phase and the following low phase of that period. The low phase always lasts half the base modulus: 8 clocks for the short pair, 16 for the long pair. The high phase lasts the same length, plus one clock when the higher modulus was captured. The output is a flip-flop, so its edges line up with the input clock and carry none of the counter's decode delay.

The controller has two states. `PH_LOW` moves to `PH_HIGH` on the low-phase terminal count, named transition LOW_DONE. On this same edge the mode is captured and the output rises. `PH_HIGH` returns to `PH_LOW` on the high-phase terminal count, named transition HIGH_DONE, and the output falls. A synchronous reset forces `PH_LOW` and clears the counter.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With ratio_sel=0 and mod_ctl=1 captured, the output period is 16 clocks: 8 high followed by 8 low.
- R2: With ratio_sel=0 and mod_ctl=0 captured, the output period is 17 clocks: 9 high followed by 8 low.
- R3: With ratio_sel=1 and mod_ctl=1 captured, the output period is 32 clocks: 16 high followed by 16 low.
- R4: With ratio_sel=1 and mod_ctl=0 captured, the output period is 33 clocks: 17 high followed by 16 low.
- R5: ratio_sel and mod_ctl are sampled only on the clock edge where div_out rises, and while rst is high. Changes between two rising edges do not alter the period in progress.
- R6: When rst is sampled high, div_out is low after that edge, and the mode inputs present are loaded. After release, div_out stays low for one full low phase of the loaded mode and rises on the 8th edge (short pair) or the 16th edge (long pair).
- R7: The low phase length depends only on the captured ratio select. The extra clock of a higher modulus appears only in the high phase, and the counter steps by exactly one within a phase.
- R8: When mod_ctl is toggled once per period, consecutive periods alternate between the lower and higher modulus of the selected pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 1 | 0 selects the 16/17 pair, 1 selects the 32/33 pair |
| mod_ctl | input | 1 | 1 selects the lower modulus, 0 the higher modulus |
| div_out | output | 1 | Registered divided output |

## Verification
On every cycle, the assertions check that the counter steps by one inside a phase, and that the low phase never exceeds the half length. They also check that the high phase never runs past its single extra clock, that the reset clears the state, and that the captured mode changes only on a rising output edge. Whether each of the four moduli produces the right split of high and low clocks can only be shown by the bench's scenarios. The same holds for mid-period input changes leaving the current period intact, and for alternating control giving alternating periods. There, a scoreboard compares every measured period with the mode driven at its rising edge.

// File: rtl/psc_pkg.sv
package psc_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/psc_mode_latch.sv
// Holds the division mode captured once per output period.
module psc_mode_latch (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic ratio_in,
    input  logic ctl_in,
    output logic wide_q,
    output logic extra_q
);
    always_ff @(posedge clk) begin
        if (rst || load) begin
            wide_q  <= ratio_in;
            extra_q <= ~ctl_in;   // control low asks for the extra clock
        end
    end
endmodule

// File: rtl/psc_phase_fsm.sv
// Two-state phase controller with a shared phase counter.
module psc_phase_fsm
    import psc_pkg::*;
#(
    parameter int HALF_SMALL = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic wide,
    input  logic extra,
    output logic out_q,
    output logic enter_high
);
    localparam int HALF_LARGE = 2 * HALF_SMALL;
    localparam int CW         = $clog2(HALF_LARGE + 2);

    phase_e          st, st_nxt;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   half_len;
    logic [CW-1:0]   phase_len;
    logic            term;

    always_comb begin
        half_len  = wide ? CW'(HALF_LARGE) : CW'(HALF_SMALL);
        phase_len = (st == PH_HIGH) ? half_len + CW'(extra) : half_len;
        term      = (cnt == phase_len - CW'(1));
    end

    always_comb begin
        unique case (st)
            PH_LOW:  st_nxt = term ? PH_HIGH : PH_LOW;   // LOW_DONE
            PH_HIGH: st_nxt = term ? PH_LOW  : PH_HIGH;  // HIGH_DONE
        endcase
    end

    assign enter_high = (st == PH_LOW) && term;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PH_LOW;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= term ? '0 : cnt + CW'(1);
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= (st_nxt == PH_HIGH);
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_q == $past(out_q)) |-> cnt == $past(cnt) + CW'(1)); // R7
    AST_LOW_FIXED: assert property (@(posedge clk) disable iff (rst)
        !out_q |-> cnt < half_len); // R7
    AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (rst)
        out_q |-> cnt <= half_len); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_q && cnt == '0)); // R6
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler #(
    parameter int HALF_SMALL = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ratio_sel,
    input  logic mod_ctl,
    output logic div_out
);
    logic mode_wide;
    logic mode_extra;
    logic rise_load;

    psc_mode_latch u_mode (
        .clk      (clk),
        .rst      (rst),
        .load     (rise_load),
        .ratio_in (ratio_sel),
        .ctl_in   (mod_ctl),
        .wide_q   (mode_wide),
        .extra_q  (mode_extra)
    );

    psc_phase_fsm #(.HALF_SMALL(HALF_SMALL)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wide       (mode_wide),
        .extra      (mode_extra),
        .out_q      (div_out),
        .enter_high (rise_load)
    );

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$rose(div_out)) |-> ($stable(mode_wide) && $stable(mode_extra))); // R5
endmodule

// File: tb/test_dual_mod_prescaler.sv
`timescale 1ns/1ps
module test_dual_mod_prescaler;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ratio_sel = 1'b0;
    logic mod_ctl = 1'b1;
    logic div_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit mon_en = 0;

    typedef struct {
        int    hi;
        int    lo;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    dual_mod_prescaler i_dual_mod_prescaler (
        .clk       (clk),
        .rst       (rst),
        .ratio_sel (ratio_sel),
        .mod_ctl   (mod_ctl),
        .div_out   (div_out)
    );

    task automatic check(string tag, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wait_rise();
        logic p;
        do begin
            p = div_out;
            @(negedge clk);
        end while (!(div_out && !p));
    endtask

    // driver: sets the mode, waits for the capturing edge, queues the expectation
    task automatic drive(bit rs, bit mc, string tag, bit glitch);
        exp_t e;
        int h;
        ratio_sel = rs;
        mod_ctl   = mc;
        wait_rise();
        h     = rs ? 16 : 8;
        e.hi  = mc ? h : h + 1;
        e.lo  = h;
        e.tag = tag;
        sb.push_back(e);
        if (glitch) begin
            repeat (3) @(negedge clk);
            ratio_sel = ~rs;   // R5: must not disturb the running period
            mod_ctl   = ~mc;
        end
    endtask

    // monitor: measures each period between rising edges
    initial begin
        logic prev;
        int   hi, lo;
        bit   started;
        exp_t e;
        prev = 1'b0; hi = 0; lo = 0; started = 0;
        forever begin
            @(negedge clk);
            if (mon_en) begin
                if (div_out && !prev) begin
                    if (started) begin
                        if (sb.size() == 0) check("R5", 1, 0, "period without expectation");
                        else begin
                            e = sb.pop_front();
                            check(e.tag, hi, e.hi, "high clocks");
                            check(e.tag, lo, e.lo, "low clocks (R7)");
                        end
                    end
                    started = 1; hi = 1; lo = 0;
                end else if (div_out) hi++;
                else lo++;
            end
            prev = div_out;
        end
    end

    initial begin
        int n;
        rst = 1'b1; ratio_sel = 1'b0; mod_ctl = 1'b1;
        repeat (3) @(negedge clk);
        check("R6", int'(div_out), 0, "output during reset");
        rst = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!div_out && n < 100);
        check("R6", n, 8, "clocks to first rise, short pair");

        repeat (2) @(negedge clk);
        rst = 1'b1; ratio_sel = 1'b1;
        @(negedge clk);
        check("R6", int'(div_out), 0, "output after reset mid-high");
        rst = 1'b0; ratio_sel = 1'b0;   // loaded value is the long pair
        n = 0;
        do begin @(negedge clk); n++; end while (!div_out && n < 100);
        check("R6", n, 16, "clocks to first rise, long pair loaded in reset");

        @(negedge clk);
        mon_en = 1;
        repeat (3) drive(1'b0, 1'b1, "R1", 1'b0);
        repeat (3) drive(1'b0, 1'b0, "R2", 1'b0);
        repeat (2) drive(1'b1, 1'b1, "R3", 1'b0);
        repeat (2) drive(1'b1, 1'b0, "R4", 1'b0);
        for (int i = 0; i < 6; i++) drive(1'b0, i[0], "R8", 1'b0);
        for (int i = 0; i < 4; i++) drive(1'b1, i[0], "R8", 1'b0);
        drive(1'b0, 1'b1, "R5", 1'b1);
        drive(1'b1, 1'b0, "R5", 1'b1);
        drive(1'b0, 1'b0, "R5", 1'b1);
        drive(1'b1, 1'b1, "R5", 1'b1);
        wait_rise();
        repeat (2) @(negedge clk);
        check("R5", sb.size(), 0, "unconsumed expectations");
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
        end
    end
endmodule